// File: doc/BRIEF.md
# Shared Instruction-Fetch Translation Cache

This block caches linear-to-physical translations for instruction fetch in one fully associative array. Small (4 KB) and large (4 MB) pages share that array. A large page never gets a single wide entry. Each 4 KB granule of a large page that a fetch touches becomes its own 4 KB entry. The frame bits of that entry come from the upper bits of the directory frame and the granule bits of the fetch address.

The fetch unit sends a linear address on a valid/ready request channel. The answer comes back as a one-cycle response pulse that carries a hit flag and the physical address. The requester must take the response in the cycle it appears, because the response channel has no back-pressure.

On a miss the block raises a valid/ready miss request to the page walker, naming the 4 KB page number. While a request is outstanding, no new lookups are accepted. The walker returns the entry on a fill channel with a page-size flag. The block then installs the entry and answers the fetch from the fill data.

A `flush` pulse, raised when the directory base is written, empties the array. A fill that belongs to a request which was already outstanding when the flush came is still used to answer the fetch, but it is not stored. Replacement uses invalid entries first, lowest index first. Once the array is full, a wrapping round-robin pointer chooses the victim.

Top module: `code_xlat_cache`

## Requirements
- R1: After reset no entry is valid, `req_ready` is 1, and `rsp_valid` and `miss_valid` are 0.
- R2: A lookup accepted in cycle N whose page number (linear bits 31:12) matches a valid entry produces `rsp_valid`=1, `rsp_hit`=1 and `rsp_phys` = {stored frame, linear bits 11:0} in cycle N+1.
- R3: A lookup with no matching entry raises `miss_valid` from cycle N+1 with `miss_vpn` = linear bits 31:12. `miss_valid` and `miss_vpn` hold until `miss_ready` is seen, and `req_ready` stays 0 until the response is given.
- R4: A fill with `fill_large`=0 accepted in cycle M produces `rsp_valid`=1, `rsp_hit`=0 and `rsp_phys` = {`fill_frame`, linear bits 11:0} in cycle M+1. It stores `fill_frame` so that later fetches in the same 4 KB page hit.
- R5: A fill with `fill_large`=1 stores and returns the frame {`fill_frame`[19:10], linear bits 21:12}. `fill_frame`[9:0] has no effect.
- R6: A fetch into a different 4 KB granule of a large page that is already cached misses, gets its own entry, and leaves the first granule's entry hitting.
- R7: A `flush` pulse invalidates every entry, so the next lookup of any previously cached page misses. `req_ready` is 0 in the flush cycle.
- R8: If `flush` occurs while a miss is outstanding, the following fill still answers the fetch but is not stored, so the same page misses again afterwards.
- R9: All 32 entries can be valid at once; 32 distinct pages filled after a flush all hit.
- R10: Free entries are used lowest index first. When all entries are valid, the victim is the entry at a round-robin pointer that starts at 0 after reset and advances by one, with wrap, on each such replacement.
- R11: Each accepted lookup gives exactly one response, and `rsp_valid` is high only in the cycle after a hit lookup or an accepted fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Directory base written; invalidate all entries |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be accepted |
| req_lin | input | 32 | Fetch linear address |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | 1 = served from the array, 0 = served from a fill |
| rsp_phys | output | 32 | Translated physical address |
| miss_valid | output | 1 | Walk request valid |
| miss_ready | input | 1 | Walker takes the request |
| miss_vpn | output | 20 | Linear page number to walk |
| fill_valid | input | 1 | Walked entry valid |
| fill_ready | output | 1 | Block waits for a fill |
| fill_frame | input | 20 | Walked frame bits 31:12 |
| fill_large | input | 1 | 1 = entry maps a 4 MB page |

## Verification
The bench goes after the large-page granule rule. A design that stored a wide 4 MB entry would hit on a second granule, and one that used the directory frame's low bits would return a wrong physical address. It raises a flush while a walk is in flight; a design that installed that stale fill would hit on the next fetch of that page. It fills the array to capacity and then past it, and checks which pages survive. A wrong replacement order evicts the wrong page, and a broken lowest-free choice overwrites a live entry before the array is full.

// File: rtl/code_xlat_pkg.sv
package code_xlat_pkg;
  localparam int LIN_W      = 32;
  localparam int PAGE_BITS  = 12;
  localparam int LARGE_BITS = 22;
  localparam int VPN_W      = LIN_W - PAGE_BITS;
  localparam int GRAN_W     = LARGE_BITS - PAGE_BITS;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MISS = 2'd1,
    ST_FILL = 2'd2
  } ctl_state_t;
endpackage

// File: rtl/code_xlat_victim.sv
module code_xlat_victim #(
  parameter int ENTRIES = 32,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               commit,
  output logic [IDX_W-1:0]   victim_idx
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  assign victim_idx = any_free ? free_idx : ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (commit && !any_free) begin
      if (ptr_q == IDX_W'(ENTRIES - 1)) ptr_q <= '0;
      else                              ptr_q <= ptr_q + 1'b1;
    end
  end

  // R10: a free slot chosen must really be free
  a_r10_free_first: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && any_free) |-> !valid_vec[victim_idx]);
endmodule

// File: rtl/code_xlat_array.sv
module code_xlat_array
  import code_xlat_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic [VPN_W-1:0]   look_vpn,
  output logic               look_hit,
  output logic [VPN_W-1:0]   look_frame,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [VPN_W-1:0]   wr_frame,
  output logic [ENTRIES-1:0] valid_vec
);
  logic [VPN_W-1:0]   tag_q   [ENTRIES];
  logic [VPN_W-1:0]   frame_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign match[g] = valid_q[g] && (tag_q[g] == look_vpn);

    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == IDX_W'(g)) begin
        tag_q[g]   <= wr_vpn;
        frame_q[g] <= wr_frame;
      end
    end
  end

  always_comb begin
    look_frame = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) look_frame = look_frame | frame_q[i];
    end
  end

  assign look_hit  = |match;
  assign valid_vec = valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  // R9: no two live entries ever carry the same page number
  a_r9_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/code_xlat_cache.sv
module code_xlat_cache
  import code_xlat_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [LIN_W-1:0]     req_lin,
  output logic                 rsp_valid,
  output logic                 rsp_hit,
  output logic [LIN_W-1:0]     rsp_phys,
  output logic                 miss_valid,
  input  logic                 miss_ready,
  output logic [VPN_W-1:0]     miss_vpn,
  input  logic                 fill_valid,
  output logic                 fill_ready,
  input  logic [VPN_W-1:0]     fill_frame,
  input  logic                 fill_large
);
  localparam int IDX_W = $clog2(ENTRIES);

  ctl_state_t         state_q;
  logic [LIN_W-1:0]   lin_q;
  logic               stale_q;
  logic               rsp_valid_q, rsp_hit_q;
  logic [LIN_W-1:0]   rsp_phys_q;

  logic               look_hit;
  logic [VPN_W-1:0]   look_frame;
  logic [ENTRIES-1:0] valid_vec;
  logic [IDX_W-1:0]   victim_idx;
  logic               req_fire, fill_fire, wr_en;
  logic [VPN_W-1:0]   new_frame;

  assign req_ready  = (state_q == ST_IDLE) && !flush;
  assign miss_valid = (state_q == ST_MISS);
  assign fill_ready = (state_q == ST_FILL);
  assign miss_vpn   = lin_q[LIN_W-1:PAGE_BITS];
  assign req_fire   = req_valid && req_ready;
  assign fill_fire  = fill_valid && fill_ready;
  assign wr_en      = fill_fire && !stale_q && !flush;

  generate
    if (GRAN_W > 0) begin : g_gran
      assign new_frame = fill_large
        ? {fill_frame[VPN_W-1:GRAN_W], lin_q[LARGE_BITS-1:PAGE_BITS]}
        : fill_frame;
    end else begin : g_nogran
      assign new_frame = fill_frame;
    end
  endgenerate

  code_xlat_array #(.ENTRIES(ENTRIES)) u_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (flush),
    .look_vpn   (req_lin[LIN_W-1:PAGE_BITS]),
    .look_hit   (look_hit),
    .look_frame (look_frame),
    .wr_en      (wr_en),
    .wr_idx     (victim_idx),
    .wr_vpn     (lin_q[LIN_W-1:PAGE_BITS]),
    .wr_frame   (new_frame),
    .valid_vec  (valid_vec)
  );

  code_xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_vec  (valid_vec),
    .commit     (wr_en),
    .victim_idx (victim_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      lin_q       <= '0;
      stale_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_phys_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (flush && state_q != ST_IDLE) stale_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (req_fire) begin
            lin_q   <= req_lin;
            stale_q <= 1'b0;
            if (look_hit) begin
              rsp_valid_q <= 1'b1;
              rsp_hit_q   <= 1'b1;
              rsp_phys_q  <= {look_frame, req_lin[PAGE_BITS-1:0]};
            end else begin
              state_q <= ST_MISS;
            end
          end
        end
        ST_MISS: begin
          if (miss_ready) state_q <= ST_FILL;
        end
        ST_FILL: begin
          if (fill_valid) begin
            rsp_valid_q <= 1'b1;
            rsp_hit_q   <= 1'b0;
            rsp_phys_q  <= {new_frame, lin_q[PAGE_BITS-1:0]};
            state_q     <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_phys  = rsp_phys_q;

  // R3: walk request is held steady until taken
  a_r3_miss_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && !miss_ready) |=> (miss_valid && $stable(miss_vpn)));
  // R3: no new lookup while a walk is pending
  a_r3_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |-> !req_ready);
  // R4: an accepted fill answers the fetch in the next cycle
  a_r4_fill_answers: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire |=> (rsp_valid && !rsp_hit));
  // R7: a lookup right after a flush cannot hit
  a_r7_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush ##1 req_fire |=> !rsp_hit);
  // R11: responses only follow a lookup or a fill
  a_r11_rsp_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_fire || fill_fire));
endmodule

// File: tb/code_xlat_cache_test.sv
module code_xlat_cache_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_lin = '0;
  logic        rsp_valid, rsp_hit;
  logic [31:0] rsp_phys;
  logic        miss_valid;
  logic        miss_ready = 1'b0;
  logic [19:0] miss_vpn;
  logic        fill_valid = 1'b0;
  logic        fill_ready;
  logic [19:0] fill_frame = '0;
  logic        fill_large = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  code_xlat_cache uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_phys(rsp_phys),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_vpn(miss_vpn),
    .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_frame(fill_frame), .fill_large(fill_large)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One fetch; answers a miss with the given walk data when one arrives.
  // flush_mid raises flush while the walk is outstanding.
  task automatic access(input string req, input logic [31:0] lin, input bit exp_hit,
                        input logic [19:0] wframe, input bit wlarge,
                        input logic [31:0] exp_phys, input bit flush_mid);
    @(negedge clk);
    req_valid = 1'b1;
    req_lin   = lin;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " hit"}, {31'd0, rsp_valid & rsp_hit}, {31'd0, exp_hit});
    if (!rsp_valid) begin
      check({req, " R3 miss_valid"}, {31'd0, miss_valid}, 32'd1);
      check({req, " R3 miss_vpn"}, {12'd0, miss_vpn}, {12'd0, lin[31:12]});
      check({req, " R3 req_ready low"}, {31'd0, req_ready}, 32'd0);
      if (flush_mid) flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      check({req, " R3 miss held"}, {31'd0, miss_valid}, 32'd1);
      miss_ready = 1'b1;
      @(negedge clk);
      miss_ready = 1'b0;
      fill_valid = 1'b1;
      fill_frame = wframe;
      fill_large = wlarge;
      @(negedge clk);
      fill_valid = 1'b0;
      check({req, " R4 fill rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
      check({req, " R4 fill rsp_hit"}, {31'd0, rsp_hit}, 32'd0);
    end
    check({req, " phys"}, rsp_phys, exp_phys);
    @(negedge clk);
    check({req, " R11 single pulse"}, {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    #0;
    check("R7 req_ready low in flush", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 req_ready", {31'd0, req_ready}, 32'd1);
    check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R1 miss_valid", {31'd0, miss_valid}, 32'd0);
    access("R1 empty", 32'h1234_5678, 1'b0, 20'hABCDE, 1'b0, 32'hABCD_E678, 1'b0);
  endtask

  task automatic t_small();
    access("R4 small fill", 32'h0040_1FF0, 1'b0, 20'h7_7001, 1'b0, 32'h7700_1FF0, 1'b0);
    access("R2 small hit", 32'h0040_1004, 1'b1, 20'h0, 1'b0, 32'h7700_1004, 1'b0);
    access("R2 hit other", 32'h1234_5000, 1'b1, 20'h0, 1'b0, 32'hABCD_E000, 1'b0);
  endtask

  task automatic t_large();
    // directory frame bits 31:22 = 0x155, low bits 0x2AA are junk (R5)
    access("R5 large fill", 32'h0080_3ABC, 1'b0, {10'h155, 10'h2AA}, 1'b1,
           {10'h155, 22'h00_3ABC}, 1'b0);
    access("R6 second granule", 32'h0080_5010, 1'b0, {10'h155, 10'h2AA}, 1'b1,
           {10'h155, 22'h00_5010}, 1'b0);
    access("R6 first still hits", 32'h0080_3000, 1'b1, 20'h0, 1'b0,
           {10'h155, 22'h00_3000}, 1'b0);
    access("R5 second hits", 32'h0080_5FFF, 1'b1, 20'h0, 1'b0,
           {10'h155, 22'h00_5FFF}, 1'b0);
  endtask

  task automatic t_flush();
    do_flush();
    access("R7 after flush", 32'h0040_1004, 1'b0, 20'h3_3003, 1'b0, 32'h3300_3004, 1'b0);
    access("R8 stale walk", 32'h0900_0010, 1'b0, 20'h4_4004, 1'b0, 32'h4400_4010, 1'b1);
    access("R8 not stored", 32'h0900_0020, 1'b0, 20'h5_5005, 1'b0, 32'h5500_5020, 1'b0);
  endtask

  task automatic t_capacity();
    do_flush();
    for (int i = 0; i < 32; i++) begin
      access("R9 fill", 32'h4000_0000 + (i << 12), 1'b0, 20'h8_0000 + 20'(i), 1'b0,
             {20'h8_0000 + 20'(i), 12'h000}, 1'b0);
    end
    for (int i = 0; i < 32; i++) begin
      access("R9 all hit", 32'h4000_0008 + (i << 12), 1'b1, 20'h0, 1'b0,
             {20'h8_0000 + 20'(i), 12'h008}, 1'b0);
    end
  endtask

  task automatic t_replace();
    // full array, pointer at 0: page 32 evicts page 0 (entry 0)
    access("R10 overflow fill", 32'h4002_0000, 1'b0, 20'h9_0000, 1'b0, 32'h9000_0000, 1'b0);
    access("R10 page2 kept", 32'h4000_2000, 1'b1, 20'h0, 1'b0, 32'h8000_2000, 1'b0);
    access("R10 page0 evicted", 32'h4000_0000, 1'b0, 20'h9_1000, 1'b0, 32'h9100_0000, 1'b0);
    access("R10 page1 evicted", 32'h4000_1000, 1'b0, 20'h9_2000, 1'b0, 32'h9200_0000, 1'b0);
    access("R10 page3 kept", 32'h4000_3000, 1'b1, 20'h0, 1'b0, 32'h8000_3000, 1'b0);
    access("R10 page32 kept", 32'h4002_0000, 1'b1, 20'h0, 1'b0, 32'h9000_0000, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_small();
    t_large();
    t_flush();
    t_capacity();
    t_replace();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule